// File: doc/BRIEF.md
# Byte Table Lookup Unit

This block resolves eight independent byte lookups into a small table held in a register array of 64-bit entries. The table spans one to four consecutive entries, starting at a base entry number. Each of the eight bytes of an index vector picks one byte of that table. The eight picked bytes form a 64-bit result. An index that falls past the end of the table produces either a zero byte or the matching byte of an old destination value, as selected by a mode input.

A start pulse captures the table-length code, the base entry, the index vector, the old destination value and the mode. The unit then reads the table entries one at a time through a synchronous read port, lowest entry first. It merges the bytes each entry supplies, loads the result register and pulses done for one cycle. Entry numbers wrap around the end of the register array. Instruction decode and the register array itself sit outside the block.

Top module: `tbl_lookup`

## Requirements
- R1: After reset, result_o is zero and done_o and rd_req_o are low.
- R2: The table is (len_code_i + 1) × 8 bytes long. Each index byte is unsigned (0 to 255) and is in range only when it is below that length.
- R3: An in-range index v selects byte v[2:0] of register entry base + v[4:3].
- R4: With keep_i low, an out-of-range index gives a result byte of zero.
- R5: With keep_i high, an out-of-range index gives byte i of old_dst_i, where byte i sits at bits 8i+7..8i.
- R6: Result byte i, at bits 8i+7..8i, comes from index byte i at the same bit position. Byte 0 is least significant.
- R7: start_i is sampled only while idle. The unit then requests entries base, base+1, … in order, one rd_req_o cycle per entry, and takes rd_data_i in the cycle after each request. done_o is high for one cycle, 2 × (len_code_i + 1) clock edges after the start edge, and result_o changes only at that edge.
- R8: Entry numbers wrap modulo the array size NREGS (a power of two) when base + offset runs past the last entry.
- R9: A start pulse while a lookup is in progress is ignored: it neither alters the result nor causes an extra done pulse.
- R10: All operands are captured at the start edge. Changes to them afterwards do not affect the running lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a lookup (sampled when idle) |
| len_code_i | input | 2 | Table length code, entries minus one |
| base_i | input | 4 | First table entry number |
| index_i | input | 64 | Eight unsigned index bytes |
| old_dst_i | input | 64 | Old destination value for keep mode |
| keep_i | input | 1 | 1: out-of-range keeps old byte, 0: zero |
| rd_req_o | output | 1 | Read request to the register array |
| rd_addr_o | output | 4 | Entry number being read |
| rd_data_i | input | 64 | Entry contents, one cycle after the request |
| result_o | output | 64 | Registered lookup result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The checker watches the timing on every cycle. It confirms that done is a single-cycle pulse, that it follows a read request by two cycles, that the result holds between done pulses, that requests never arrive back to back, and that successive requests within one lookup step the entry number by one, wrapping at the end of the array. The byte contents cannot be seen at the port boundary on every cycle. Which byte each index picks, the zero versus keep handling of out-of-range indices, the length boundaries, the ignored mid-lookup start and the capture of operands at the start edge are shown only by the bench's scenarios, which compare results against a model of the register array.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_ACC  = 2'd2
    } phase_e;
endpackage

// File: rtl/tbl_lane.sv
// One result byte: the fill value chosen at start, and the byte picked from the entry being read.
module tbl_lane #(
    parameter int LANES    = 8,
    parameter int MAX_REGS = 4
) (
    input  logic [tbl_pkg::BYTE_W-1:0]          live_idx,
    input  logic [$clog2(MAX_REGS)-1:0]         live_len,
    input  logic [tbl_pkg::BYTE_W-1:0]          old_byte,
    input  logic                                keep,
    input  logic [tbl_pkg::BYTE_W-1:0]          held_idx,
    input  logic [$clog2(MAX_REGS)-1:0]         held_len,
    input  logic [$clog2(MAX_REGS)-1:0]         cur_reg,
    input  logic [LANES*tbl_pkg::BYTE_W-1:0]    reg_data,
    output logic [tbl_pkg::BYTE_W-1:0]          fill_byte,
    output logic                                hit,
    output logic [tbl_pkg::BYTE_W-1:0]          pick_byte
);
    localparam int BW   = tbl_pkg::BYTE_W;
    localparam int SELW = $clog2(LANES);
    localparam int RW   = $clog2(MAX_REGS);

    logic [BW-1:0] live_off;
    logic [BW-1:0] held_off;
    logic          live_in;
    logic          held_in;

    always_comb begin
        live_off = live_idx >> SELW;
        held_off = held_idx >> SELW;
        live_in  = live_off <= BW'(live_len);
        held_in  = held_off <= BW'(held_len);
        fill_byte = (!live_in && keep) ? old_byte : '0;
        hit       = held_in && (held_off[RW-1:0] == cur_reg);
        pick_byte = '0;
        for (int j = 0; j < LANES; j++) begin
            if (held_idx[SELW-1:0] == SELW'(j)) begin
                pick_byte = reg_data[j*BW +: BW];
            end
        end
    end
endmodule

// File: rtl/tbl_addr_gen.sv
// Entry number for the current step, wrapping at the array end, plus the last-step flag.
module tbl_addr_gen #(
    parameter int NREGS    = 16,
    parameter int MAX_REGS = 4
) (
    input  logic [$clog2(NREGS)-1:0]    base,
    input  logic [$clog2(MAX_REGS)-1:0] step,
    input  logic [$clog2(MAX_REGS)-1:0] len_code,
    output logic [$clog2(NREGS)-1:0]    addr,
    output logic                        last
);
    localparam int AW = $clog2(NREGS);

    always_comb begin
        addr = base + AW'(step);
        last = (step == len_code);
    end
endmodule

// File: rtl/tbl_lookup.sv
module tbl_lookup #(
    parameter int LANES    = 8,
    parameter int MAX_REGS = 4,
    parameter int NREGS    = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic [$clog2(MAX_REGS)-1:0]           len_code_i,
    input  logic [$clog2(NREGS)-1:0]              base_i,
    input  logic [LANES*tbl_pkg::BYTE_W-1:0]      index_i,
    input  logic [LANES*tbl_pkg::BYTE_W-1:0]      old_dst_i,
    input  logic                                  keep_i,
    output logic                                  rd_req_o,
    output logic [$clog2(NREGS)-1:0]              rd_addr_o,
    input  logic [LANES*tbl_pkg::BYTE_W-1:0]      rd_data_i,
    output logic [LANES*tbl_pkg::BYTE_W-1:0]      result_o,
    output logic                                  done_o
);
    import tbl_pkg::*;

    localparam int BW = BYTE_W;
    localparam int DW = LANES * BW;
    localparam int RW = $clog2(MAX_REGS);
    localparam int AW = $clog2(NREGS);

    typedef struct packed {
        phase_e          ph;
        logic [RW-1:0]   k;
        logic [RW-1:0]   len;
        logic [AW-1:0]   base;
        logic [DW-1:0]   idx;
        logic [DW-1:0]   acc;
        logic [DW-1:0]   res;
        logic            done;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0]    fill_vec;
    logic [DW-1:0]    pick_vec;
    logic [LANES-1:0] hit_vec;
    logic [DW-1:0]    merged;
    logic [AW-1:0]    cur_addr;
    logic             last_step;

    // Per-byte resolution, one lane per result byte.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        tbl_lane #(
            .LANES    (LANES),
            .MAX_REGS (MAX_REGS)
        ) u_lane (
            .live_idx  (index_i[i*BW +: BW]),
            .live_len  (len_code_i),
            .old_byte  (old_dst_i[i*BW +: BW]),
            .keep      (keep_i),
            .held_idx  (st_q.idx[i*BW +: BW]),
            .held_len  (st_q.len),
            .cur_reg   (st_q.k),
            .reg_data  (rd_data_i),
            .fill_byte (fill_vec[i*BW +: BW]),
            .hit       (hit_vec[i]),
            .pick_byte (pick_vec[i*BW +: BW])
        );
        assign merged[i*BW +: BW] = hit_vec[i] ? pick_vec[i*BW +: BW]
                                               : st_q.acc[i*BW +: BW];
    end

    tbl_addr_gen #(
        .NREGS    (NREGS),
        .MAX_REGS (MAX_REGS)
    ) u_addr (
        .base     (st_q.base),
        .step     (st_q.k),
        .len_code (st_q.len),
        .addr     (cur_addr),
        .last     (last_step)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph   = PH_REQ;
                    st_d.k    = '0;
                    st_d.len  = len_code_i;
                    st_d.base = base_i;
                    st_d.idx  = index_i;
                    st_d.acc  = fill_vec;
                end
            end
            PH_REQ: begin
                st_d.ph = PH_ACC;
            end
            PH_ACC: begin
                st_d.acc = merged;
                if (last_step) begin
                    st_d.res  = merged;
                    st_d.done = 1'b1;
                    st_d.ph   = PH_IDLE;
                end else begin
                    st_d.k  = st_q.k + 1'b1;
                    st_d.ph = PH_REQ;
                end
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_req_o  = (st_q.ph == PH_REQ);
    assign rd_addr_o = cur_addr;
    assign result_o  = st_q.res;
    assign done_o    = st_q.done;
endmodule

// File: rtl/tbl_lookup_chk.sv
module tbl_lookup_chk #(
    parameter int LANES = 8,
    parameter int NREGS = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rd_req_o,
    input logic [$clog2(NREGS)-1:0] rd_addr_o,
    input logic [LANES*8-1:0]       result_o,
    input logic                     done_o
);
    localparam int AW = $clog2(NREGS);

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: result changes only together with done
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R7: done arrives two cycles after the final request
    a_r7_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rd_req_o, 2));

    // R7: one request cycle per entry, never back to back
    a_r7_req_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R8: consecutive entries step by one, wrapping at the array end
    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && $past(rd_req_o, 2)) |-> rd_addr_o == AW'($past(rd_addr_o, 2) + 1'b1));
endmodule

bind tbl_lookup tbl_lookup_chk #(
    .LANES (LANES),
    .NREGS (NREGS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .result_o  (result_o),
    .done_o    (done_o)
);

// File: tb/tbl_lookup_test.sv
`timescale 1ns/1ps
module tbl_lookup_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  len_code_i = '0;
    logic [3:0]  base_i = '0;
    logic [63:0] index_i = '0;
    logic [63:0] old_dst_i = '0;
    logic        keep_i = 1'b0;
    logic        rd_req_o;
    logic [3:0]  rd_addr_o;
    logic [63:0] rd_data_i = '0;
    logic [63:0] result_o;
    logic        done_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    tbl_lookup uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_code_i(len_code_i),
        .base_i(base_i), .index_i(index_i), .old_dst_i(old_dst_i), .keep_i(keep_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .result_o(result_o), .done_o(done_o)
    );

    // Register array model: entry r, byte b holds (16r + b) ^ 0x5A, one-cycle read.
    function automatic logic [7:0] mem_byte(int r, int b);
        return 8'((r * 16 + b) ^ 8'h5A);
    endfunction

    always @(posedge clk) begin
        logic [63:0] w;
        for (int b = 0; b < 8; b++) w[b*8 +: 8] = mem_byte(int'(rd_addr_o), b);
        rd_data_i <= w;
    end

    // Expected result from R2..R6 and R8.
    function automatic logic [63:0] model(logic [1:0] len, logic [3:0] base, logic keep,
                                          logic [63:0] idx, logic [63:0] old);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            int v = int'(idx[i*8 +: 8]);
            if (v < (int'(len) + 1) * 8)
                r[i*8 +: 8] = mem_byte((int'(base) + v / 8) % 16, v % 8);
            else
                r[i*8 +: 8] = keep ? old[i*8 +: 8] : 8'h00;
        end
        return r;
    endfunction

    task automatic check(logic ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One lookup; poke >= 0 pulses start again mid-lookup (R9). Operands are scrambled after the start edge (R10).
    task automatic run_op(logic [1:0] len, logic [3:0] base, logic keep,
                          logic [63:0] idx, logic [63:0] old, int poke, string tag);
        logic [63:0] exp;
        int n;
        int reqs;
        int extra;
        exp = model(len, base, keep, idx, old);
        @(negedge clk);
        len_code_i = len; base_i = base; keep_i = keep; index_i = idx; old_dst_i = old;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        len_code_i = ~len; base_i = base + 4'd7; keep_i = ~keep;
        index_i = ~idx; old_dst_i = ~old;
        n = 0; reqs = 0;
        while (n < 40) begin
            if (rd_req_o) begin
                check(rd_addr_o == 4'((int'(base) + reqs) % 16), {tag, " R7 R8 R3 addr order"},
                      64'(rd_addr_o), 64'((int'(base) + reqs) % 16));
                reqs++;
            end
            if (done_o) break;
            start_i = (n == poke);
            @(posedge clk); #1;
            n++;
        end
        start_i = 1'b0;
        check(n == 2 * (int'(len) + 1), {tag, " R7 latency"}, 64'(n), 64'(2 * (int'(len) + 1)));
        check(reqs == int'(len) + 1, {tag, " R7 request count"}, 64'(reqs), 64'(int'(len) + 1));
        check(result_o == exp, {tag, " R2 R3 R4 R5 R6 R10 result"}, result_o, exp);
        extra = 0;
        for (int c = 0; c < 8; c++) begin
            @(posedge clk); #1;
            if (done_o || rd_req_o) extra++;
        end
        check(extra == 0, {tag, " R7 R9 no extra activity"}, 64'(extra), 64'd0);
        check(result_o == exp, {tag, " R7 result held"}, result_o, exp);
    endtask

    localparam int NV = 10;
    // {len, base, keep, index, old}
    localparam logic [134:0] VEC [NV] = '{
        {2'd0, 4'd0,  1'b0, 64'h0706050403020100, 64'h0000000000000000},
        {2'd0, 4'd2,  1'b0, 64'h0807FF0010010620, 64'h1111111111111111},
        {2'd0, 4'd2,  1'b1, 64'h0807FF0010010620, 64'hA1A2A3A4A5A6A7A8},
        {2'd1, 4'd5,  1'b0, 64'h0F10080700110E09, 64'h7777777777777777},
        {2'd1, 4'd5,  1'b1, 64'h0F10080700110E09, 64'hC0C1C2C3C4C5C6C7},
        {2'd2, 4'd9,  1'b1, 64'h1718100F08070080, 64'hB0B1B2B3B4B5B6B7},
        {2'd3, 4'd1,  1'b0, 64'h1F201817100F0800, 64'h5555555555555555},
        {2'd3, 4'd1,  1'b1, 64'h00011E40FF211905, 64'hDEADBEEFCAFEF00D},
        {2'd3, 4'd14, 1'b0, 64'h000810181F170F07, 64'h0000000000000000},
        {2'd2, 4'd15, 1'b1, 64'h1710080018FF1209, 64'h0123456789ABCDEF}
    };

    initial begin : watchdog
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(result_o == 64'd0, "R1 result after reset", result_o, 64'd0);
        check(!done_o && !rd_req_o, "R1 done/req low in reset", {62'd0, done_o, rd_req_o}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(!done_o && !rd_req_o && result_o == 64'd0, "R1 idle after reset release",
              result_o, 64'd0);

        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][134:133], VEC[v][132:129], VEC[v][128], VEC[v][127:64],
                   VEC[v][63:0], -1, $sformatf("vec%0d", v));
        end

        // R9: start pulse while busy is ignored
        run_op(2'd3, 4'd6, 1'b0, 64'h001F200918273140, 64'd0, 3, "r9_busy_start");
        // R8: wrap from the last entry
        run_op(2'd1, 4'd15, 1'b0, 64'h0F0E090807060100, 64'd0, -1, "r8_wrap");
        // R2 R4 R5: every index past 31 is out of range for the longest table
        run_op(2'd3, 4'd3, 1'b1, 64'hFF80402120FE7F3F, 64'h8877665544332211, -1, "r5_all_out");
        run_op(2'd3, 4'd3, 1'b0, 64'hFF80402120FE7F3F, 64'h8877665544332211, -1, "r4_all_out");
        // R6: reversed byte order of indices
        run_op(2'd0, 4'd8, 1'b0, 64'h0001020304050607, 64'd0, -1, "r6_reverse");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule